// File: doc/BRIEF.md
# Fixed-Home Block Directory Slice

This block is one slice of a distributed directory for a multiprocessor in which node memories act only as large caches. Blocks move freely from node to node, but the directory record for each block stays put. It sits on the node picked by the low-order bits of the block address. Every node that misses in its local memory sends the request straight to that node. There is no search through a hierarchy. The slice looks up where the block is now held and in what state. It then sends a forward command to the current holder, or an allocate grant back to the requester, and rewrites the record to show who holds the block afterwards.

Each record holds a state (uncached, shared or exclusive), the node that holds the last copy (the owner), and a presence vector with one bit per node. Requests enter a small FIFO and are handled strictly one at a time. After a forward has gone out, the slice waits for a completion pulse before it takes the next request. A separate owner-move input lets a node report that it has pushed a last-copy block into another node's memory.

Top module: `fcoma_dir_slice`

## Requirements
- R1: After reset every record is uncached, `fwd_valid` and `inv_valid` are low, and `req_ready` is high.
- R2: The home node of an address is its low 3 bits. A request whose home differs from `SLICE_ID` is sent out with command 3 (redirect), with `fwd_target` set to the home node, and no record changes.
- R3: A request of either kind to an uncached block produces command 2 (allocate) with `fwd_target` equal to the requester. The record becomes exclusive, with the requester as owner and as the only present node.
- R4: A read to a shared or exclusive block produces command 0 (read) aimed at the owner. The requester's presence bit is set, the state becomes shared, and the owner is unchanged.
- R5: A write to a shared or exclusive block produces command 1 (write) aimed at the owner. In the same cycle, `inv_mask` carries the present nodes other than the owner and the requester, and `inv_valid` is high only if that mask is non-zero. The record becomes exclusive, with the requester as owner and as the only present node.
- R6: An owner-move (`upd_valid`) for an address homed at this slice replaces only the owner field. State and presence bits stay as they were, and later forwards go to the new owner. If the address is homed elsewhere, the owner-move is ignored.
- R7: `fwd_valid` is a one-cycle pulse. No second forward appears until `fwd_done` has been seen.
- R8: Waiting requests are served in arrival order. The queue holds `QDEPTH` (default 4) entries. `req_ready` is low while the queue is full, and a request offered while `req_ready` is low is dropped.
- R9: With the slice idle and the queue empty, the forward for a request appears two rising edges after the request is presented. After `fwd_done`, a queued request is forwarded two edges after the `fwd_done` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Miss request present |
| req_ready | output | 1 | Queue can take a request |
| req_node | input | 3 | Requesting node |
| req_addr | input | 8 | Block address |
| req_write | input | 1 | 1 = write miss, 0 = read miss |
| upd_valid | input | 1 | Owner-move message present |
| upd_node | input | 3 | New owner of the block |
| upd_addr | input | 8 | Block address of the owner-move |
| fwd_valid | output | 1 | Forward command pulse |
| fwd_target | output | 3 | Node the command is sent to |
| fwd_req | output | 3 | Original requester |
| fwd_addr | output | 8 | Block address |
| fwd_cmd | output | 2 | 0 read, 1 write, 2 allocate, 3 redirect |
| inv_valid | output | 1 | Invalidate set present with this forward |
| inv_mask | output | 8 | Nodes to invalidate |
| fwd_done | input | 1 | Current forward has completed |

## Verification
The bench presents each request on a falling edge. It samples `fwd_*` and `inv_*` at the second falling edge after that, which is where one queue register and one output register place the result. After a `fwd_done` pulse, a queued request is expected at the second falling edge after the pulse. Record contents cannot be read directly, so the bench infers them from later forwards and compares those against its own model. The random phase interleaves owner-moves with requests and never lets the two reach the same edge.

// File: rtl/dir_pkg.sv
package dir_pkg;
    localparam int NODES  = 8;
    localparam int NODE_W = $clog2(NODES);
    localparam int ADDR_W = 8;
    localparam int IDX_W  = ADDR_W - NODE_W;

    typedef enum logic [1:0] {ST_UNC = 2'd0, ST_SHR = 2'd1, ST_EXC = 2'd2} dir_state_e;
    typedef enum logic [1:0] {CMD_READ = 2'd0, CMD_WRITE = 2'd1,
                              CMD_ALLOC = 2'd2, CMD_REDIR = 2'd3} fwd_cmd_e;

    typedef struct packed {
        dir_state_e        st;
        logic [NODE_W-1:0] owner;
        logic [NODES-1:0]  sharers;
    } dir_entry_t;

    typedef struct packed {
        logic [NODE_W-1:0] node;
        logic [ADDR_W-1:0] addr;
        logic              wr;
    } dir_req_t;
endpackage

// File: rtl/dir_req_fifo.sv
module dir_req_fifo
    import dir_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     push,
    input  dir_req_t din,
    input  logic     pop,
    output dir_req_t dout,
    output logic     empty,
    output logic     full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        dir_req_t [DEPTH-1:0] mem;
        logic [PW-1:0]        wp;
        logic [PW-1:0]        rp;
        logic [PW:0]          cnt;
    } fifo_t;

    fifo_t s_q, s_d;

    assign empty = (s_q.cnt == '0);
    assign full  = (s_q.cnt == (PW+1)'(DEPTH));
    assign dout  = s_q.mem[s_q.rp];

    always_comb begin
        s_d = s_q;
        if (push && !full) begin
            s_d.mem[s_q.wp] = din;
            s_d.wp = (s_q.wp == PW'(DEPTH-1)) ? '0 : s_q.wp + 1'b1;
        end
        if (pop && !empty) begin
            s_d.rp = (s_q.rp == PW'(DEPTH-1)) ? '0 : s_q.rp + 1'b1;
        end
        s_d.cnt = s_q.cnt + (PW+1)'(push && !full) - (PW+1)'(pop && !empty);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/dir_entry_table.sv
module dir_entry_table
    import dir_pkg::*;
#(
    parameter int ENTRIES = 1 << IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output dir_entry_t        rd_ent,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  dir_entry_t        wr_ent,
    input  logic              mv_en,
    input  logic [IDX_W-1:0]  mv_idx,
    input  logic [NODE_W-1:0] mv_owner
);
    dir_entry_t [ENTRIES-1:0] tbl_q, tbl_d;

    assign rd_ent = tbl_q[rd_idx];

    always_comb begin
        tbl_d = tbl_q;
        for (int i = 0; i < ENTRIES; i++) begin
            if (wr_en && wr_idx == IDX_W'(i)) tbl_d[i] = wr_ent;
            if (mv_en && mv_idx == IDX_W'(i)) tbl_d[i].owner = mv_owner;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < ENTRIES; i++) tbl_q[i] <= '{st: ST_UNC, owner: '0, sharers: '0};
        end else begin
            tbl_q <= tbl_d;
        end
    end
endmodule

// File: rtl/dir_decide.sv
module dir_decide
    import dir_pkg::*;
#(
    parameter int SLICE_ID = 0
) (
    input  dir_req_t          req,
    input  dir_entry_t        cur,
    output fwd_cmd_e          cmd,
    output logic [NODE_W-1:0] target,
    output logic [NODES-1:0]  inv,
    output logic              upd,
    output dir_entry_t        nxt
);
    localparam logic [NODE_W-1:0] MY_HOME = SLICE_ID[NODE_W-1:0];

    logic [NODES-1:0] req_bit, own_bit;

    always_comb begin
        req_bit = {{(NODES-1){1'b0}}, 1'b1} << req.node;
        own_bit = {{(NODES-1){1'b0}}, 1'b1} << cur.owner;
        cmd     = CMD_REDIR;
        target  = req.addr[NODE_W-1:0];
        inv     = '0;
        upd     = 1'b0;
        nxt     = cur;
        if (req.addr[NODE_W-1:0] == MY_HOME) begin
            upd = 1'b1;
            if (cur.st == ST_UNC) begin
                cmd    = CMD_ALLOC;
                target = req.node;
                nxt    = '{st: ST_EXC, owner: req.node, sharers: req_bit};
            end else if (!req.wr) begin
                cmd    = CMD_READ;
                target = cur.owner;
                nxt    = '{st: ST_SHR, owner: cur.owner, sharers: cur.sharers | req_bit};
            end else begin
                cmd    = CMD_WRITE;
                target = cur.owner;
                inv    = cur.sharers & ~own_bit & ~req_bit;
                nxt    = '{st: ST_EXC, owner: req.node, sharers: req_bit};
            end
        end
    end
endmodule

// File: rtl/fcoma_dir_slice.sv
module fcoma_dir_slice
    import dir_pkg::*;
#(
    parameter int SLICE_ID = 0,
    parameter int QDEPTH   = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [2:0]  req_node,
    input  logic [7:0]  req_addr,
    input  logic        req_write,
    input  logic        upd_valid,
    input  logic [2:0]  upd_node,
    input  logic [7:0]  upd_addr,
    output logic        fwd_valid,
    output logic [2:0]  fwd_target,
    output logic [2:0]  fwd_req,
    output logic [7:0]  fwd_addr,
    output logic [1:0]  fwd_cmd,
    output logic        inv_valid,
    output logic [7:0]  inv_mask,
    input  logic        fwd_done
);
    localparam logic [NODE_W-1:0] MY_HOME = SLICE_ID[NODE_W-1:0];

    typedef struct packed {
        logic              busy;
        logic              fv;
        logic [NODE_W-1:0] target;
        logic [NODE_W-1:0] rq;
        logic [ADDR_W-1:0] addr;
        fwd_cmd_e          cmd;
        logic              iv;
        logic [NODES-1:0]  imask;
    } ctl_t;

    ctl_t       c_q, c_d;
    dir_req_t   in_req, head;
    logic       q_empty, q_full, pop;
    dir_entry_t cur_ent, nxt_ent;
    fwd_cmd_e   d_cmd;
    logic [NODE_W-1:0] d_target;
    logic [NODES-1:0]  d_inv;
    logic       d_upd, tbl_we, mv_en;

    assign in_req = '{node: req_node, addr: req_addr, wr: req_write};

    dir_req_fifo #(.DEPTH(QDEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(req_valid), .din(in_req),
        .pop(pop), .dout(head), .empty(q_empty), .full(q_full)
    );

    assign mv_en = upd_valid && (upd_addr[NODE_W-1:0] == MY_HOME);

    dir_entry_table u_tbl (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(head.addr[ADDR_W-1:NODE_W]), .rd_ent(cur_ent),
        .wr_en(tbl_we), .wr_idx(head.addr[ADDR_W-1:NODE_W]), .wr_ent(nxt_ent),
        .mv_en(mv_en), .mv_idx(upd_addr[ADDR_W-1:NODE_W]), .mv_owner(upd_node)
    );

    dir_decide #(.SLICE_ID(SLICE_ID)) u_dec (
        .req(head), .cur(cur_ent), .cmd(d_cmd), .target(d_target),
        .inv(d_inv), .upd(d_upd), .nxt(nxt_ent)
    );

    always_comb begin
        c_d       = c_q;
        c_d.fv    = 1'b0;
        c_d.iv    = 1'b0;
        c_d.imask = '0;
        pop       = 1'b0;
        tbl_we    = 1'b0;
        if (!c_q.busy && !q_empty) begin
            pop        = 1'b1;
            tbl_we     = d_upd;
            c_d.busy   = 1'b1;
            c_d.fv     = 1'b1;
            c_d.target = d_target;
            c_d.rq     = head.node;
            c_d.addr   = head.addr;
            c_d.cmd    = d_cmd;
            c_d.iv     = |d_inv;
            c_d.imask  = d_inv;
        end else if (c_q.busy && fwd_done) begin
            c_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '{busy: 1'b0, fv: 1'b0, target: '0, rq: '0, addr: '0,
                             cmd: CMD_READ, iv: 1'b0, imask: '0};
        else        c_q <= c_d;
    end

    assign req_ready  = !q_full;
    assign fwd_valid  = c_q.fv;
    assign fwd_target = c_q.target;
    assign fwd_req    = c_q.rq;
    assign fwd_addr   = c_q.addr;
    assign fwd_cmd    = c_q.cmd;
    assign inv_valid  = c_q.iv;
    assign inv_mask   = c_q.imask;
endmodule

// File: rtl/dir_slice_chk.sv
module dir_slice_chk #(
    parameter int SLICE_ID = 0
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fwd_valid,
    input logic [2:0] fwd_target,
    input logic [2:0] fwd_req,
    input logic [7:0] fwd_addr,
    input logic [1:0] fwd_cmd,
    input logic       inv_valid,
    input logic [7:0] inv_mask,
    input logic       fwd_done
);
    logic outstanding;

    always_ff @(posedge clk) begin
        if (!rst_n)         outstanding <= 1'b0;
        else if (fwd_done)  outstanding <= 1'b0;
        else if (fwd_valid) outstanding <= 1'b1;
    end

    AST_FWD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |=> !fwd_valid); // R7
    AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
        fwd_valid |-> !outstanding); // R7
    AST_ALLOC_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_cmd == 2'd2) |-> (fwd_target == fwd_req)); // R3
    AST_REDIR_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_cmd == 2'd3) |-> (fwd_target == fwd_addr[2:0] && fwd_addr[2:0] != 3'(SLICE_ID))); // R2
    AST_LOCAL_HOME: assert property (@(posedge clk) disable iff (!rst_n)
        (fwd_valid && fwd_cmd != 2'd3) |-> (fwd_addr[2:0] == 3'(SLICE_ID))); // R2
    AST_INV_WITH_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        inv_valid |-> (fwd_valid && fwd_cmd == 2'd1 && inv_mask != 8'd0
                       && !inv_mask[fwd_req] && !inv_mask[fwd_target])); // R5
endmodule

bind fcoma_dir_slice dir_slice_chk #(.SLICE_ID(SLICE_ID)) u_chk (
    .clk(clk), .rst_n(rst_n), .fwd_valid(fwd_valid), .fwd_target(fwd_target),
    .fwd_req(fwd_req), .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd),
    .inv_valid(inv_valid), .inv_mask(inv_mask), .fwd_done(fwd_done)
);

// File: tb/fcoma_dir_slice_bench.sv
module fcoma_dir_slice_bench;
    localparam int SID = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0, req_write = 1'b0, upd_valid = 1'b0, fwd_done = 1'b0;
    logic [2:0] req_node = '0, upd_node = '0;
    logic [7:0] req_addr = '0, upd_addr = '0;
    logic       req_ready, fwd_valid, inv_valid;
    logic [2:0] fwd_target, fwd_req;
    logic [7:0] fwd_addr, inv_mask;
    logic [1:0] fwd_cmd;

    int checks = 0;
    int errors = 0;

    // bench model of the records
    logic [1:0] m_st  [32];
    logic [2:0] m_own [32];
    logic [7:0] m_shr [32];

    // expected forward of the last computed request
    logic [1:0] e_cmd;
    logic [2:0] e_tgt;
    logic [7:0] e_inv;

    always #2 clk = ~clk;

    fcoma_dir_slice #(.SLICE_ID(SID), .QDEPTH(4)) u_fcoma_dir_slice (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_node(req_node), .req_addr(req_addr), .req_write(req_write),
        .upd_valid(upd_valid), .upd_node(upd_node), .upd_addr(upd_addr),
        .fwd_valid(fwd_valid), .fwd_target(fwd_target), .fwd_req(fwd_req),
        .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd), .inv_valid(inv_valid),
        .inv_mask(inv_mask), .fwd_done(fwd_done)
    );

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // model: compute expected forward and advance the records
    task automatic model_req(logic [2:0] n, logic [7:0] a, logic w);
        int i = int'(a[7:3]);
        logic [7:0] rb = 8'd1 << n;
        logic [7:0] ob;
        e_inv = 8'd0;
        if (a[2:0] != 3'(SID)) begin
            e_cmd = 2'd3; e_tgt = a[2:0];
        end else if (m_st[i] == 2'd0) begin
            e_cmd = 2'd2; e_tgt = n;
            m_st[i] = 2'd2; m_own[i] = n; m_shr[i] = rb;
        end else if (!w) begin
            e_cmd = 2'd0; e_tgt = m_own[i];
            m_st[i] = 2'd1; m_shr[i] = m_shr[i] | rb;
        end else begin
            ob = 8'd1 << m_own[i];
            e_cmd = 2'd1; e_tgt = m_own[i];
            e_inv = m_shr[i] & ~ob & ~rb;
            m_st[i] = 2'd2; m_own[i] = n; m_shr[i] = rb;
        end
    endtask

    task automatic present(logic [2:0] n, logic [7:0] a, logic w);
        req_valid = 1'b1; req_node = n; req_addr = a; req_write = w;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic check_fwd(string tag, logic [2:0] n, logic [7:0] a);
        check({tag, " valid"}, 32'(fwd_valid), 32'd1);
        check({tag, " cmd"}, 32'(fwd_cmd), 32'(e_cmd));
        check({tag, " target"}, 32'(fwd_target), 32'(e_tgt));
        check({tag, " req"}, 32'(fwd_req), 32'(n));
        check({tag, " addr"}, 32'(fwd_addr), 32'(a));
        check({tag, " inv_mask"}, 32'(inv_mask), 32'(e_inv));
        check({tag, " inv_valid"}, 32'(inv_valid), 32'(e_inv != 8'd0));
    endtask

    task automatic done_pulse();
        fwd_done = 1'b1;
        @(negedge clk);
        fwd_done = 1'b0;
    endtask

    // full transaction from idle: request, exact-latency forward, completion
    task automatic xact(string tag, logic [2:0] n, logic [7:0] a, logic w);
        model_req(n, a, w);
        present(n, a, w);
        @(negedge clk);              // R9: two edges after presentation
        check_fwd(tag, n, a);
        done_pulse();
        check({tag, " pulse R7"}, 32'(fwd_valid), 32'd0);
    endtask

    task automatic owner_move(logic [2:0] n, logic [7:0] a);
        upd_valid = 1'b1; upd_node = n; upd_addr = a;
        @(negedge clk);
        upd_valid = 1'b0;
        if (a[2:0] == 3'(SID)) m_own[int'(a[7:3])] = n;
    endtask

    function automatic logic [7:0] haddr(int idx);
        return {idx[4:0], 3'(SID)};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) begin m_st[i] = 0; m_own[i] = 0; m_shr[i] = 0; end
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 fwd_valid", 32'(fwd_valid), 32'd0);
        check("R1 inv_valid", 32'(inv_valid), 32'd0);
        check("R1 req_ready", 32'(req_ready), 32'd1);

        // R3 allocate on uncached, read and write paths
        xact("R3 alloc read", 3'd1, haddr(2), 1'b0);
        xact("R3 alloc write", 3'd5, haddr(3), 1'b1);
        // R4 reads add sharers
        xact("R4 read excl", 3'd2, haddr(2), 1'b0);
        xact("R4 read shared", 3'd4, haddr(2), 1'b0);
        // R5 write invalidates others (owner 1, sharers 1,2,4; requester 2)
        xact("R5 write", 3'd2, haddr(2), 1'b1);
        // R5 write with no other sharer: no invalidate
        xact("R5 write noinv", 3'd6, haddr(2), 1'b1);
        // R2 redirect and record untouched
        xact("R2 redirect", 3'd0, {5'd2, 3'd5}, 1'b1);
        xact("R2 untouched", 3'd7, haddr(2), 1'b0);
        // R6 owner move changes target only
        owner_move(3'd3, haddr(2));
        xact("R6 new owner", 3'd0, haddr(2), 1'b1);
        owner_move(3'd1, {5'd2, 3'd0});
        xact("R6 foreign ignored", 3'd4, haddr(2), 1'b0);

        // R8 queue fill, order, drop; R7 hold until done
        begin
            logic [2:0] qn [5];
            logic [7:0] qa [5];
            for (int k = 0; k < 5; k++) begin qn[k] = 3'(k + 1); qa[k] = haddr(10 + k); end
            model_req(qn[0], qa[0], 1'b0);
            present(qn[0], qa[0], 1'b0);
            @(negedge clk);
            check_fwd("R8 q0", qn[0], qa[0]);
            for (int k = 1; k < 5; k++) present(qn[k], qa[k], 1'b0);
            check("R8 full ready", 32'(req_ready), 32'd0);
            present(3'd7, haddr(20), 1'b1); // dropped
            check("R7 held", 32'(fwd_valid), 32'd0);
            for (int k = 1; k < 5; k++) begin
                model_req(qn[k], qa[k], 1'b0);
                done_pulse();
                @(negedge clk);             // R9 after completion
                check_fwd("R8 order", qn[k], qa[k]);
            end
            done_pulse();
            repeat (6) @(negedge clk);
            check("R8 dropped", 32'(fwd_valid), 32'd0);
            // dropped request left block 20 uncached: allocate expected
            xact("R8 drop state", 3'd2, haddr(20), 1'b0);
        end

        // random phase
        for (int t = 0; t < 400; t++) begin
            logic [2:0] n = 3'($urandom_range(0, 7));
            logic [7:0] a = haddr($urandom_range(0, 5));
            if ($urandom_range(0, 7) == 0) a[2:0] = 3'($urandom_range(0, 7));
            if ($urandom_range(0, 5) == 0) owner_move(3'($urandom_range(0, 7)), a);
            else xact("R9 random", n, a, 1'($urandom_range(0, 1)));
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule